// File: doc/BRIEF.md
# Host PIO Window Decoder

This block sits behind the host-side request port of a bus bridge. It takes one incoming programmed-I/O address per cycle and classifies it against the bridge's fixed address map. The map has the bridge's own register file, the internal and external translation RAMs, per-slot and per-function type 0 configuration space, a single type 1 configuration window, an interrupt-acknowledge port, eight device I/O windows, a flash window, and three wide alias ranges. The alias ranges turn into 32-bit memory, 64-bit memory or I/O cycles on the downstream bus.

For each valid request the block produces three things one cycle later: a one-hot target select, the device, slot and function indices where the target uses them, and the byte offset of the address from the base of the window it hit. The device windows differ in size: windows 0 and 1 each span 2 MB, and windows 2 to 7 each span 1 MB. An address that falls in a reserved hole, or outside every window, raises an invalid flag and selects nothing.

The block has no state machine. Its only state is the output register stage, loaded on every clock.

Top module: `pio_win_decoder`

## Requirements
- R1: The outputs are registered. `out_valid` equals `req_valid` from the previous clock. When the previous `req_valid` was 0, every other output is 0. While `rst_n` is low, every output is 0.
- R2: `tgt_onehot` bit positions are: 0 registers, 1 internal translation RAM, 2 type 0 config, 3 type 1 config, 4 interrupt-acknowledge, 5 external translation RAM, 6 device window, 7 flash, 8 memory-32 alias, 9 memory-64 alias, 10 I/O alias. At most one bit is set. Exactly one bit is set for a valid matched address.
- R3: 0x0_0000_0000–0x0_0000_FFFF selects bit 0 with offset = address. 0x0_0001_0000–0x0_0001_03FF selects bit 1 with offset = address − 0x10000.
- R4: 0x20000–0x27FFF is type 0 config. The slot is (address − 0x20000) / 0x1000. The remainder r selects function r / 0x100 with offset r mod 0x100. A remainder of 0x800 or more is invalid.
- R5: 0x28000–0x28FFF selects bit 3 with offset = address − 0x28000. 0x30000–0x30007 selects bit 4 with offset = address − 0x30000.
- R6: 0x80000–0xFFFFF selects bit 5 with offset = address − 0x80000.
- R7: Device window n starts at 0x200000 + n·0x200000 for n < 2, and at 0x600000 + (n−2)·0x100000 for n from 2 to 7. A hit selects bit 6, `dev_idx` = n, and offset = address − base.
- R8: 0xC00000–0xFFFFFF selects bit 7 with offset = address − 0xC00000.
- R9: 0x4000_0000–0x7FFF_FFFF selects bit 8. 0x8000_0000–0xBFFF_FFFF selects bit 9. 0x1_0000_0000–0x1_FFFF_FFFF selects bit 10. In each case the offset is address minus the range start.
- R10: All other addresses raise `addr_bad` with zero target, indices and offset. These include 0x10400–0x1FFFF, 0x29000–0x2FFFF, 0x30008–0x7FFFF, 0x100000–0x1FFFFF, 0x100_0000–0x3FFF_FFFF and 0xC000_0000–0xFFFF_FFFF.
- R11: `dev_idx` is 0 unless bit 6 is selected. `slot_idx` and `func_idx` are 0 unless bit 2 is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request address is valid this cycle |
| req_addr | input | 33 | Host-side PIO byte address |
| out_valid | output | 1 | Decode result valid |
| tgt_onehot | output | 11 | One-hot target select (see R2) |
| addr_bad | output | 1 | Address matched no window |
| dev_idx | output | 3 | Device window index |
| slot_idx | output | 3 | Configuration slot index |
| func_idx | output | 3 | Configuration function index |
| win_off | output | 32 | Offset from the matched window base |

## Verification
The local 16 MB space is swept in 256-byte steps, with a varying low byte at each step. This sweep reaches every window, every hole, every device index and every slot/function pair, and separates the 2 MB device windows from the 1 MB ones. A coarse sweep in 16 MB steps across the whole 33-bit space separates the three alias ranges from the unmapped gaps. Explicit probes at one byte below, at, and one byte above every window edge catch off-by-one base or limit errors, including the split between function space and the invalid upper half of each configuration slot. Cycles with `req_valid` low, and cycles under reset, confirm that nothing leaks into the quiet outputs.

// File: rtl/pio_dec_pkg.sv
package pio_dec_pkg;
    localparam int ADDR_W = 33;
    localparam int LOC_W  = 24;
    localparam int OFF_W  = 32;
    localparam int IDX_W  = 3;
    localparam int NTGT   = 11;

    typedef enum logic [3:0] {
        T_REGS  = 4'd0,
        T_IRAM  = 4'd1,
        T_CFG0  = 4'd2,
        T_CFG1  = 4'd3,
        T_IACK  = 4'd4,
        T_ERAM  = 4'd5,
        T_DEVIO = 4'd6,
        T_FLASH = 4'd7,
        T_MEM32 = 4'd8,
        T_MEM64 = 4'd9,
        T_BUSIO = 4'd10,
        T_NONE  = 4'd15
    } tgt_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [IDX_W-1:0] dev;
        logic [IDX_W-1:0] slot;
        logic [IDX_W-1:0] func;
        logic [OFF_W-1:0] off;
    } dec_res_t;
endpackage

// File: rtl/pio_local_dec.sv
module pio_local_dec
    import pio_dec_pkg::*;
(
    input  logic [LOC_W-1:0] a,
    output dec_res_t         r
);
    logic [3:0] region;
    logic [3:0] sub;
    logic [3:0] dev_rel;

    assign region  = a[23:20];
    assign sub     = a[19:16];
    assign dev_rel = region - 4'd2;

    always_comb begin
        r     = '0;
        r.tgt = T_NONE;
        unique case (region)
            4'h0: begin
                if (sub == 4'h0) begin
                    r.tgt = T_REGS;
                    r.off = OFF_W'(a[15:0]);
                end else if (sub == 4'h1) begin
                    if (a[15:10] == 6'd0) begin
                        r.tgt = T_IRAM;
                        r.off = OFF_W'(a[9:0]);
                    end
                end else if (sub == 4'h2) begin
                    if (!a[15]) begin
                        if (!a[11]) begin
                            r.tgt  = T_CFG0;
                            r.slot = a[14:12];
                            r.func = a[10:8];
                            r.off  = OFF_W'(a[7:0]);
                        end
                    end else if (a[14:12] == 3'd0) begin
                        r.tgt = T_CFG1;
                        r.off = OFF_W'(a[11:0]);
                    end
                end else if (sub == 4'h3) begin
                    if (a[15:3] == 13'd0) begin
                        r.tgt = T_IACK;
                        r.off = OFF_W'(a[2:0]);
                    end
                end else if (sub[3]) begin
                    r.tgt = T_ERAM;
                    r.off = OFF_W'(a[18:0]);
                end
            end
            4'h1: ;
            4'h2, 4'h3, 4'h4, 4'h5: begin
                r.tgt = T_DEVIO;
                r.dev = IDX_W'(dev_rel >> 1);
                r.off = OFF_W'({region[0], a[19:0]});
            end
            4'h6, 4'h7, 4'h8, 4'h9, 4'hA, 4'hB: begin
                r.tgt = T_DEVIO;
                r.dev = IDX_W'(region - 4'd4);
                r.off = OFF_W'(a[19:0]);
            end
            default: begin
                r.tgt = T_FLASH;
                r.off = OFF_W'(a[21:0]);
            end
        endcase
    end
endmodule

// File: rtl/pio_space_sel.sv
module pio_space_sel
    import pio_dec_pkg::*;
(
    input  logic [ADDR_W-1:0] a,
    input  dec_res_t          loc,
    output dec_res_t          r
);
    always_comb begin
        r     = '0;
        r.tgt = T_NONE;
        if (a[32]) begin
            r.tgt = T_BUSIO;
            r.off = a[31:0];
        end else begin
            unique case (a[31:30])
                2'b00: begin
                    if (a[29:24] == 6'd0) r = loc;
                end
                2'b01: begin
                    r.tgt = T_MEM32;
                    r.off = OFF_W'(a[29:0]);
                end
                2'b10: begin
                    r.tgt = T_MEM64;
                    r.off = OFF_W'(a[29:0]);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pio_win_decoder.sv
module pio_win_decoder
    import pio_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              out_valid,
    output logic [NTGT-1:0]   tgt_onehot,
    output logic              addr_bad,
    output logic [IDX_W-1:0]  dev_idx,
    output logic [IDX_W-1:0]  slot_idx,
    output logic [IDX_W-1:0]  func_idx,
    output logic [OFF_W-1:0]  win_off
);
    dec_res_t        loc_res;
    dec_res_t        fin_res;
    logic [NTGT-1:0] sel_d;
    logic            miss_d;

    pio_local_dec u_loc (
        .a (req_addr[LOC_W-1:0]),
        .r (loc_res)
    );

    pio_space_sel u_sel (
        .a   (req_addr),
        .loc (loc_res),
        .r   (fin_res)
    );

    for (genvar i = 0; i < NTGT; i++) begin : g_sel
        assign sel_d[i] = (fin_res.tgt == tgt_e'(i));
    end

    assign miss_d = (fin_res.tgt == T_NONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            tgt_onehot <= '0;
            addr_bad   <= 1'b0;
            dev_idx    <= '0;
            slot_idx   <= '0;
            func_idx   <= '0;
            win_off    <= '0;
        end else begin
            out_valid  <= req_valid;
            tgt_onehot <= req_valid ? sel_d : '0;
            addr_bad   <= req_valid && miss_d;
            dev_idx    <= req_valid ? fin_res.dev  : '0;
            slot_idx   <= req_valid ? fin_res.slot : '0;
            func_idx   <= req_valid ? fin_res.func : '0;
            win_off    <= req_valid ? fin_res.off  : '0;
        end
    end
endmodule

// File: rtl/pio_win_decoder_chk.sv
module pio_win_decoder_chk
    import pio_dec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              out_valid,
    input logic [NTGT-1:0]   tgt_onehot,
    input logic              addr_bad,
    input logic [IDX_W-1:0]  dev_idx,
    input logic [IDX_W-1:0]  slot_idx,
    input logic [IDX_W-1:0]  func_idx,
    input logic [OFF_W-1:0]  win_off
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> out_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> (!out_valid && tgt_onehot == '0 && !addr_bad && win_off == '0)); // R1
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(tgt_onehot)); // R2
    AST_VALID_COVERED: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (addr_bad != ($countones(tgt_onehot) == 1))); // R2
    AST_BAD_NO_TARGET: assert property (@(posedge clk) disable iff (!rst_n) addr_bad |-> (tgt_onehot == '0 && win_off == '0)); // R10
    AST_IO_PASS: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_addr[32]) |=> (tgt_onehot[10] && win_off == $past(req_addr[31:0]))); // R9
    AST_BIG_DEV: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_addr[32:24] == 9'd0 && (req_addr[23:21] == 3'd1 || req_addr[23:21] == 3'd2)) |=> (tgt_onehot[6] && dev_idx == {2'b00, $past(req_addr[22])})); // R7
    AST_DEV_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !tgt_onehot[6] |-> dev_idx == '0); // R11
    AST_CFG_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !tgt_onehot[2] |-> (slot_idx == '0 && func_idx == '0)); // R11
endmodule

bind pio_win_decoder pio_win_decoder_chk u_chk (.*);

// File: tb/sim_pio_win_decoder.sv
module sim_pio_win_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [32:0] req_addr = '0;
    logic        out_valid;
    logic [10:0] tgt_onehot;
    logic        addr_bad;
    logic [2:0]  dev_idx;
    logic [2:0]  slot_idx;
    logic [2:0]  func_idx;
    logic [31:0] win_off;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pio_win_decoder u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .out_valid(out_valid), .tgt_onehot(tgt_onehot), .addr_bad(addr_bad),
        .dev_idx(dev_idx), .slot_idx(slot_idx), .func_idx(func_idx), .win_off(win_off)
    );

    function automatic void model(input logic [32:0] a, output int t, output logic [2:0] d,
                                  output logic [2:0] s, output logic [2:0] f, output logic [31:0] o);
        longint unsigned x;
        longint unsigned r;
        longint unsigned n;
        x = longint'(a);
        t = -1; d = '0; s = '0; f = '0; o = '0;
        if (x < 64'h10000) begin
            t = 0; o = 32'(x);
        end else if (x >= 64'h10000 && x < 64'h10400) begin
            t = 1; o = 32'(x - 64'h10000);
        end else if (x >= 64'h20000 && x < 64'h28000) begin
            r = (x - 64'h20000) % 64'h1000;
            if (r < 64'h800) begin
                t = 2;
                s = 3'((x - 64'h20000) / 64'h1000);
                f = 3'(r / 64'h100);
                o = 32'(r % 64'h100);
            end
        end else if (x >= 64'h28000 && x < 64'h29000) begin
            t = 3; o = 32'(x - 64'h28000);
        end else if (x >= 64'h30000 && x < 64'h30008) begin
            t = 4; o = 32'(x - 64'h30000);
        end else if (x >= 64'h80000 && x < 64'h100000) begin
            t = 5; o = 32'(x - 64'h80000);
        end else if (x >= 64'h200000 && x < 64'h600000) begin
            n = (x - 64'h200000) / 64'h200000;
            t = 6; d = 3'(n); o = 32'(x - (64'h200000 + n * 64'h200000));
        end else if (x >= 64'h600000 && x < 64'hC00000) begin
            n = 2 + (x - 64'h600000) / 64'h100000;
            t = 6; d = 3'(n); o = 32'(x - (64'h600000 + (n - 2) * 64'h100000));
        end else if (x >= 64'hC00000 && x < 64'h1000000) begin
            t = 7; o = 32'(x - 64'hC00000);
        end else if (x >= 64'h40000000 && x < 64'h80000000) begin
            t = 8; o = 32'(x - 64'h40000000);
        end else if (x >= 64'h80000000 && x < 64'hC0000000) begin
            t = 9; o = 32'(x - 64'h80000000);
        end else if (x >= 64'h100000000 && x < 64'h200000000) begin
            t = 10; o = 32'(x - 64'h100000000);
        end
    endfunction

    // Drive at a falling edge, sample at the next falling edge (one register stage).
    task automatic apply(input logic v, input logic [32:0] a);
        int t;
        logic [2:0] d, s, f;
        logic [31:0] o;
        logic [10:0] e_sel;
        logic e_bad;
        string tag;
        req_valid = v;
        req_addr  = a;
        @(negedge clk);
        model(a, t, d, s, f, o);
        e_bad = v && (t < 0);
        e_sel = (v && t >= 0) ? (11'd1 << t) : 11'd0;
        if (!v) begin d = '0; s = '0; f = '0; o = '0; end
        if (e_bad) o = '0;
        case (t)
            0, 1: tag = "R3";
            2: tag = "R4";
            3, 4: tag = "R5";
            5: tag = "R6";
            6: tag = "R7";
            7: tag = "R8";
            8, 9, 10: tag = "R9";
            default: tag = "R10";
        endcase
        if (!v) tag = "R1";
        n_checks++;
        if (out_valid !== v || tgt_onehot !== e_sel || addr_bad !== e_bad || dev_idx !== d ||
            slot_idx !== s || func_idx !== f || win_off !== o) begin
            n_errors++;
            $display("FAIL %s (sel per R2, indices per R11) addr=%h got v=%b sel=%b bad=%b d=%0d s=%0d f=%0d off=%h exp v=%b sel=%b bad=%b d=%0d s=%0d f=%0d off=%h",
                     tag, a, out_valid, tgt_onehot, addr_bad, dev_idx, slot_idx, func_idx, win_off,
                     v, e_sel, e_bad, d, s, f, o);
        end
    endtask

    initial begin
        logic [32:0] edges [0:24];
        logic [32:0] a;
        edges = '{33'h10000, 33'h10400, 33'h20000, 33'h20800, 33'h21000, 33'h27800,
                  33'h28000, 33'h29000, 33'h30000, 33'h30008, 33'h80000, 33'h100000,
                  33'h200000, 33'h400000, 33'h600000, 33'h700000, 33'hB00000, 33'hC00000,
                  33'h1000000, 33'h40000000, 33'h80000000, 33'hC0000000, 33'h100000000,
                  33'h1FFFFFFFF, 33'h0A00000};

        // R1: outputs quiet under reset even with a valid request present
        req_valid = 1'b1;
        req_addr  = 33'h0C00123;
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || tgt_onehot !== '0 || addr_bad !== 1'b0 || win_off !== '0 ||
            dev_idx !== '0 || slot_idx !== '0 || func_idx !== '0) begin
            n_errors++;
            $display("FAIL R1 reset state got v=%b sel=%b bad=%b off=%h exp all zero",
                     out_valid, tgt_onehot, addr_bad, win_off);
        end
        rst_n = 1'b1;

        apply(1'b1, 33'h0);
        apply(1'b0, 33'h0400000);   // R1: idle cycle after a valid one
        apply(1'b0, 33'h1_2345_6789);

        // Local 16 MB space, 256-byte steps with varying low byte
        for (int i = 0; i < 65536; i++) begin
            a = 33'(i) * 33'h100 + 33'((i * 37) & 255);
            apply(1'b1, a);
        end

        // Whole 33-bit space in 16 MB steps
        for (int i = 0; i < 512; i++) begin
            a = 33'(i) * 33'h1000000 + 33'((i * 32'h12345) & 32'hFFFFFF);
            apply(1'b1, a);
            if ((i % 64) == 0) apply(1'b0, a);
        end

        // Edges: one below, at, one above
        for (int k = 0; k < 25; k++) begin
            apply(1'b1, edges[k] - 33'd1);
            apply(1'b1, edges[k]);
            apply(1'b1, edges[k] + 33'd1);
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired got running exp finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule